// File: doc/BRIEF.md
# Flash query and identifier responder

This block supplies the read data a parallel NOR flash returns while it sits in its parameter-query mode or its identifier mode. The command decoder that selects the mode and the flash array itself live elsewhere. Each read presents a bus byte address, an access size and a mode select. One clock later the block returns a 32-bit word built the way the physical bank of flash parts would drive it.

The bank is described by three elaboration-time parameters: the bank width, the width each device is run at, and the widest mode the device supports. All three are powers of two from 1 to 4 bytes. The block rescales the bus address into a table or identifier index. It builds the answer of one device and copies that answer into every device slot of the bank. When an access is wider than the bank, it combines several lookups. The 82-entry parameter table is generated at elaboration from the sector size and block count.

Top module: `flash_qry_resp`

## Requirements
- R1: While reset is asserted and after its release, until the first read, `rd_valid` is 0 and `rd_data` is 0.
- R2: `rd_valid` is 1 in exactly the cycle after a cycle with `rd_en` high. `rd_data` changes only on the clock edge that samples `rd_en` high.
- R3: The lookup index is the byte address shifted right by log2(BANK_W) + log2(MAX_DEV_W) − log2(DEV_W), so the address bits below that shift have no effect.
- R4: In query mode (`rd_id` = 0), an index of 0x52 or more yields 0 for that lookup.
- R5: Query entries 0x10, 0x11, 0x12 read 0x51, 0x52, 0x59 ("QRY"). Entries 0x13 and 0x14 read 0x01 and 0x00, and 0x15 reads 0x31. Entries 0x31 to 0x35 read 0x50, 0x52, 0x49, 0x31, 0x30 ("PRI10").
- R6: Entry 0x27 holds log2 of the per-device size, and 0x2A holds 8 for a one-byte bank and 11 otherwise. Entry 0x2C holds 1. Entries 0x2D and 0x2E hold (blocks − 1), low byte first. Entries 0x2F and 0x30 hold the per-device sector size / 256, low byte first. The per-device sector size is SECTOR_BYTES / (BANK_W / DEV_W).
- R7: With a one-byte device mode on a wider part, the table byte appears in every byte lane of the bank. With any other device width below MAX_DEV_W, query lookups return 0.
- R8: In identifier mode (`rd_id` = 1), only the low 8 bits of the index are decoded. Index 0 gives MFR_ID, index 1 gives DEV_ID and all others give 0. The low DEV_W bytes of the ID are copied into every DEV_W-byte slice of the bank.
- R9: An access wider than the bank makes lookup k at byte address + k·BANK_W·BANK_W. It places the result in bytes k·BANK_W to k·BANK_W + BANK_W − 1 of `rd_data`.
- R10: `rd_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 and 3 = 4 bytes. Bytes of `rd_data` at or above the access size read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request this cycle |
| rd_id | input | 1 | 1 = identifier mode, 0 = parameter-query mode |
| rd_addr | input | ADDR_W | Bus byte address |
| rd_size | input | 2 | Access size code |
| rd_data | output | 32 | Response, registered |
| rd_valid | output | 1 | Response valid, one cycle after `rd_en` |

## Verification
The hardest case to reach is the wide access whose second lookup crosses the end of the table. In that case one half of the word carries a replicated table byte and the other half must be zero. Reaching it needs the address scaling, the per-lookup stride and the range test to line up on the same access. The stimulus reaches it by sweeping every index past the table end with every size code, in the configuration with a one-byte device mode on a two-byte part. Another case is the identifier decode ignoring index bits above the low eight. It is reached by reading at an index of 256 or more, where a correct design must answer as at index 0 and 1.

// File: rtl/flash_qry_resp.sv
module flash_qry_resp #(
  parameter int BANK_W       = 2,
  parameter int DEV_W        = 1,
  parameter int MAX_DEV_W    = 2,
  parameter int SECTOR_BYTES = 65536,
  parameter int NUM_BLOCKS   = 32,
  parameter int ADDR_W       = 21,
  parameter logic [15:0] MFR_ID = 16'h5EA7,
  parameter logic [15:0] DEV_ID = 16'h3C19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_id,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_size,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);

  function automatic int lowest_set(input logic [63:0] v);
    int n;
    n = 0;
    for (int i = 63; i >= 0; i--) if (v[i]) n = i;
    return n;
  endfunction

  localparam int SH        = $clog2(BANK_W) + $clog2(MAX_DEV_W) - $clog2(DEV_W);
  localparam int NDEV      = BANK_W / DEV_W;
  localparam int NQ        = 4 / BANK_W;
  localparam int SECT_DEV  = SECTOR_BYTES / NDEV;
  localparam logic [63:0] DEV_BYTES = 64'(SECT_DEV) * 64'(NUM_BLOCKS);
  localparam logic [7:0]  SIZE_LOG  = 8'(lowest_set(DEV_BYTES));
  localparam logic [7:0]  WBUF_LOG  = (BANK_W == 1) ? 8'd8 : 8'd11;
  localparam logic [15:0] BLK_M1    = 16'(NUM_BLOCKS - 1);
  localparam logic [31:0] SECT_U    = 32'(SECT_DEV);
  localparam logic [ADDR_W-1:0] TBL_LEN = ADDR_W'(82);

  function automatic logic [7:0] tbl_byte(input logic [6:0] i);
    logic [7:0] b;
    case (i)
      7'h10: b = 8'h51;  7'h11: b = 8'h52;  7'h12: b = 8'h59;
      7'h13: b = 8'h01;  7'h15: b = 8'h31;
      7'h1B: b = 8'h45;  7'h1C: b = 8'h55;
      7'h1F: b = 8'h07;  7'h20: b = 8'h07;  7'h21: b = 8'h0A;
      7'h23: b = 8'h04;  7'h24: b = 8'h04;  7'h25: b = 8'h04;
      7'h27: b = SIZE_LOG;
      7'h28: b = 8'h02;
      7'h2A: b = WBUF_LOG;
      7'h2C: b = 8'h01;
      7'h2D: b = BLK_M1[7:0];
      7'h2E: b = BLK_M1[15:8];
      7'h2F: b = SECT_U[15:8];
      7'h30: b = SECT_U[23:16];
      7'h31: b = 8'h50;  7'h32: b = 8'h52;  7'h33: b = 8'h49;
      7'h34: b = 8'h31;  7'h35: b = 8'h30;
      7'h3F: b = 8'h01;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [31:0] bank_resp(input logic id_mode, input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] ix;
    logic [31:0] dev, r;
    logic [7:0]  b;
    ix  = a >> SH;
    dev = '0;
    r   = '0;
    if (id_mode) begin
      case (ix[7:0])
        8'd0:    dev = {16'h0, MFR_ID};
        8'd1:    dev = {16'h0, DEV_ID};
        default: dev = '0;
      endcase
    end else if (ix < TBL_LEN) begin
      b = tbl_byte(ix[6:0]);
      if (DEV_W == MAX_DEV_W)   dev = {24'h0, b};
      else if (DEV_W == 1)      dev = {b, b, b, b} & ~(32'hFFFF_FFFF << (8 * MAX_DEV_W));
      else                      dev = '0;
    end
    for (int s = 0; s < NDEV; s++) r[s*DEV_W*8 +: DEV_W*8] = dev[DEV_W*8-1:0];
    return r;
  endfunction

  logic [2:0]  nbytes;
  logic [31:0] combined, nxt;

  assign nbytes = (rd_size == 2'd0) ? 3'd1 : (rd_size == 2'd1) ? 3'd2 : 3'd4;

  always_comb begin
    logic [31:0] q;
    combined = '0;
    for (int k = 0; k < NQ; k++) begin
      q = bank_resp(rd_id, rd_addr + ADDR_W'(k * BANK_W * BANK_W));
      if (k == 0 || 3'(k * BANK_W) < nbytes)
        combined[k*BANK_W*8 +: BANK_W*8] = q[BANK_W*8-1:0];
    end
    for (int y = 0; y < 4; y++)
      nxt[y*8 +: 8] = (3'(y) < nbytes) ? combined[y*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= nxt;
    end
  end

  logic [ADDR_W-1:0] req_ix;
  assign req_ix = rd_addr >> SH;

  assert_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (!rd_valid && $stable(rd_data)));
  assert_narrow_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_size == 2'd0) |=> (rd_data[31:8] == 24'h0));
  assert_past_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_id && nbytes <= 3'(BANK_W) && req_ix >= TBL_LEN) |=> (rd_data == 32'h0));
  assert_id_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_id && nbytes <= 3'(BANK_W) && req_ix[7:0] > 8'd1) |=> (rd_data == 32'h0));

  generate
    if (DEV_W == 1 && MAX_DEV_W > 1 && BANK_W > 1) begin : g_x8_lanes
      assert_lanes_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_id && nbytes >= 3'(BANK_W)) |=>
        (rd_data[BANK_W*8-1:0] == {BANK_W{rd_data[7:0]}}));
    end
  endgenerate

endmodule

// File: tb/sim_flash_qry_resp.sv
module sim_flash_qry_resp;
  localparam int BANK_W = 2, DEV_W = 1, MAX_DEV_W = 2;
  localparam int SECTOR_BYTES = 65536, NUM_BLOCKS = 32, ADDR_W = 21;
  localparam logic [15:0] MFR = 16'h5EA7, DID = 16'h3C19;
  localparam int SECT_DEV = SECTOR_BYTES / (BANK_W / DEV_W);
  localparam int SIZE_LOG = $clog2(SECT_DEV) + $clog2(NUM_BLOCKS);

  logic clk = 0, rst_n = 0, rd_en = 0, rd_id = 0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [1:0] rd_size = '0;
  logic [31:0] rd_data;
  logic rd_valid;
  int checks = 0, fails = 0;
  logic [31:0] got;
  logic got_v;

  always #2.5 clk = ~clk;

  flash_qry_resp #(.BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W),
    .SECTOR_BYTES(SECTOR_BYTES), .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W),
    .MFR_ID(MFR), .DEV_ID(DID)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_id(rd_id), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input int a, input logic id, input int sz);
    @(negedge clk);
    rd_en = 1; rd_id = id; rd_addr = ADDR_W'(a); rd_size = 2'(sz);
    @(negedge clk);
    rd_en = 0;
    got = rd_data; got_v = rd_valid;
  endtask

  function automatic logic [8:0] known(input int i);
    case (i)
      16: return {1'b1, 8'h51}; 17: return {1'b1, 8'h52}; 18: return {1'b1, 8'h59};
      19: return {1'b1, 8'h01}; 20: return {1'b1, 8'h00}; 21: return {1'b1, 8'h31};
      49: return {1'b1, 8'h50}; 50: return {1'b1, 8'h52}; 51: return {1'b1, 8'h49};
      52: return {1'b1, 8'h31}; 53: return {1'b1, 8'h30};
      39: return {1'b1, 8'(SIZE_LOG)};
      42: return {1'b1, (BANK_W == 1) ? 8'd8 : 8'd11};
      44: return {1'b1, 8'h01};
      45: return {1'b1, 8'((NUM_BLOCKS - 1) & 255)};
      46: return {1'b1, 8'(((NUM_BLOCKS - 1) >> 8) & 255)};
      47: return {1'b1, 8'((SECT_DEV >> 8) & 255)};
      48: return {1'b1, 8'((SECT_DEV >> 16) & 255)};
      default: return 9'h0;
    endcase
  endfunction

  function automatic logic [31:0] bytemask(input int sz);
    return (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] hold;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'h0, rd_valid}, 32'h0);
    chk("R1 data in reset", rd_data, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid after reset", {31'h0, rd_valid}, 32'h0);
    chk("R1 data after reset", rd_data, 32'h0);

    do_read(16 * 4, 0, 1);
    chk("R2 valid after request", {31'h0, got_v}, 32'h1);
    hold = got;
    @(negedge clk);
    chk("R2 valid drops when idle", {31'h0, rd_valid}, 32'h0);
    chk("R2 data held when idle", rd_data, hold);
    rd_addr = '1; rd_size = 2'd2; rd_id = 1;
    @(negedge clk);
    chk("R2 data ignores inputs without request", rd_data, hold);

    do_read(16 * 4 + 3, 0, 1);
    chk("R3 low address bits ignored", got, 32'h0000_5151);
    do_read(16 * 4 + 4, 0, 0);
    chk("R3 next index", got, 32'h0000_0052);

    for (int i = 0; i < 96; i++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] e [2];
        logic [31:0] exp;
        string tag;
        do_read(i * 4 + (i % 4), 0, s);
        for (int g = 0; g < 2; g++) begin
          logic [8:0] k;
          k = known(i + g);
          if (i + g >= 82) e[g] = 8'h00;
          else if (k[8]) e[g] = k[7:0];
          else e[g] = got[g*16 +: 8];
        end
        exp = {e[1], e[1], e[0], e[0]} & bytemask(s);
        if (i >= 82) tag = "R4 beyond table";
        else if (i + 1 >= 82 && s >= 2) tag = "R9 R4 second lookup past end";
        else if (i == 39 || i == 42 || (i >= 44 && i <= 48)) tag = "R6 geometry";
        else if (known(i) != 9'h0) tag = "R5 signature";
        else tag = "R7 lane repeat";
        if (s < 2) tag = {tag, " R10 size"};
        else tag = {tag, " R9 wide"};
        chk($sformatf("%s idx %0d size %0d", tag, i, s), got, exp);
      end
    end

    do_read(0, 1, 2);
    chk("R8 R9 manufacturer and device ids", got, {DID[7:0], DID[7:0], MFR[7:0], MFR[7:0]});
    do_read(4, 1, 1);
    chk("R8 device id", got, {16'h0, DID[7:0], DID[7:0]});
    do_read(8, 1, 2);
    chk("R8 other index zero", got, 32'h0);
    do_read(256 * 4, 1, 0);
    chk("R8 low eight bits decoded", got, {24'h0, MFR[7:0]});
    do_read(257 * 4, 1, 3);
    chk("R8 R10 wrap index with zero upper lookup", got, {16'h0, DID[7:0], DID[7:0]});
    do_read(1 * 4 + 2, 1, 0);
    chk("R8 R10 byte read", got, {24'h0, DID[7:0]});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule